// File: doc/BRIEF.md
# SDRAM Special-Command Issuer with Refresh Scheduler

This block produces the SDRAM commands that are not data transfers. Software brings the memory up by choosing a command type in a small mode register and then writing anywhere in the SDRAM address window. Each such write sends one command of the chosen type to the device and moves no data. Going back to the normal code hands accesses to the access sequencer again. The usual bring-up order is: one no-operation, one precharge of all banks, eight auto-refresh commands, one load-mode-register, and then normal mode.

A programmable down-counter measures the refresh interval. When it expires it raises a pending refresh, and that request wins over host accesses. The scheduler waits until the sequencer has finished its current access. It then precharges every bank, waits the row-precharge time, issues auto-refresh, waits the row-cycle time, and finally pulses a signal telling the sequencer to forget every open row. Access grants are held back for that whole span. If a second expiry arrives while a request is still waiting, a sticky overrun flag is set.

Top module: `sdram_cmd_refresh`

## Requirements
- R1: After synchronous reset the mode is normal (0), the command pins show deselect (cs_n, ras_n, cas_n, we_n all 1), a10 and the address are 0, rows_inval and rfsh_overrun are 0, and the refresh timer is stopped.
- R2: A mode write with a code from 0 to 4 is stored. A write with code 5, 6 or 7 is ignored, and the previous mode stays in force.
- R3: In modes 1 to 4, a granted write drives exactly one command, for one cycle, on the cycle after the grant. The command pins are {cs_n,ras_n,cas_n,we_n}. The codes are: mode 1 no-operation 0111; mode 2 precharge-all 0010 with sd_a10=1; mode 3 load-mode-register 0000 with sd_addr=0x020 (burst length 1, CAS latency 2 in bits 6:4); mode 4 auto-refresh 0001. At every other time the pins show deselect 1111, with a10=0 and address 0.
- R4: In mode 0 a granted access raises seq_start in the grant cycle and drives no command. In modes 1 to 4 a granted read drives no command, and seq_start stays low in every mode other than 0.
- R5: acc_gnt is high only when acc_req is high, seq_busy is low, and no refresh is pending or in progress.
- R6: Writing a non-zero period P loads the timer. A refresh becomes pending P cycles after the write cycle and then every P cycles. Writing 0 stops the timer.
- R7: Refresh service places precharge-all (a10=1) one cycle after service starts. Auto-refresh follows TRP_CYC cycles later. A one-cycle rows_inval pulse follows TRC_CYC cycles after the auto-refresh, and grants may resume in that same cycle.
- R8: A pending refresh does not start while seq_busy is high. It starts in the first cycle in which seq_busy is low.
- R9: If the timer expires again while a refresh is still pending, rfsh_overrun is set and stays set until reset.
- R10: When a refresh is pending and an access is requested in the same cycle, the refresh goes first and the access is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_code | input | 3 | Mode code to write |
| rfsh_we | input | 1 | Refresh period write strobe |
| rfsh_period | input | CNT_W | Refresh interval in cycles (0 stops the timer) |
| acc_req | input | 1 | Host access into the SDRAM window |
| acc_write | input | 1 | Access is a write |
| seq_busy | input | 1 | Access sequencer is still running an access |
| acc_gnt | output | 1 | Access accepted this cycle |
| seq_start | output | 1 | Accepted access forwarded to the sequencer (mode 0) |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a10 | output | 1 | Dedicated address bit 10 (all-bank select) |
| sd_addr | output | ADDR_W | Address bus value for load-mode-register |
| rows_inval | output | 1 | Pulse: forget all open rows |
| rfsh_overrun | output | 1 | Sticky missed-refresh flag |

## Verification
A wrong count in the interval or wait counters moves the precharge, auto-refresh and invalidate pulses off their expected cycles. The first refresh after a period write therefore shows this within a few cycles of the expected precharge. A mode register that latched an illegal code, or a wrong command decode, shows on the command pins one cycle after the next granted write. A lost or doubled pending flag shows up in two ways: a missing or extra precharge one interval later, or grants that go on when they should be held back. A faulty overrun flag shows as soon as the sequencer has been held busy across two expiries.

// File: rtl/sdcr_pkg.sv
package sdcr_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORMAL = 3'd0,
    MODE_NOP    = 3'd1,
    MODE_PREALL = 3'd2,
    MODE_LMR    = 3'd3,
    MODE_AREF   = 3'd4
  } sd_mode_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_DESL = 4'b1111;
  localparam sd_cmd_t CMD_NOP  = 4'b0111;
  localparam sd_cmd_t CMD_PRE  = 4'b0010;
  localparam sd_cmd_t CMD_REF  = 4'b0001;
  localparam sd_cmd_t CMD_LMR  = 4'b0000;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_RP = 2'd1,
    ST_WAIT_RC = 2'd2
  } rf_state_e;

endpackage

// File: rtl/sdcr_mode_reg.sv
module sdcr_mode_reg
  import sdcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_code,
  output sd_mode_e          mode_o
);

  sd_mode_e mode_q;
  logic     code_ok;

  assign code_ok = (wr_code <= MODE_W'(MODE_AREF));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_NORMAL;
    end else if (wr_en && code_ok) begin
      mode_q <= sd_mode_e'(wr_code);
    end
  end

  assign mode_o = mode_q;

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (rst)
    mode_q <= MODE_AREF);

  assert_bad_code_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_code > MODE_W'(MODE_AREF))) |=> $stable(mode_q));

endmodule

// File: rtl/sdcr_refresh_timer.sv
module sdcr_refresh_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             period_we,
  input  logic [CNT_W-1:0] period_in,
  input  logic             take,
  output logic             pending_o,
  output logic             overrun_o
);

  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pending_q;
  logic             overrun_q;
  logic             expire;

  assign expire = (period_q != '0) && (cnt_q == CNT_W'(1)) && !period_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      cnt_q    <= '0;
    end else if (period_we) begin
      period_q <= period_in;
      cnt_q    <= period_in;
    end else if (period_q != '0) begin
      cnt_q <= (cnt_q == CNT_W'(1)) ? period_q : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (expire) begin
        pending_q <= 1'b1;
      end else if (take) begin
        pending_q <= 1'b0;
      end
      if (expire && pending_q && !take) begin
        overrun_q <= 1'b1;
      end
    end
  end

  assign pending_o = pending_q;
  assign overrun_o = overrun_q;

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overrun_q |=> overrun_q);

  assert_reload_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    period_we |=> (cnt_q == $past(period_in)));

  assert_pending_from_expiry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(pending_q) |-> ($past(cnt_q) == CNT_W'(1)));

endmodule

// File: rtl/sdcr_cmd_fsm.sv
module sdcr_cmd_fsm
  import sdcr_pkg::*;
#(
  parameter int              TRP_CYC  = 2,
  parameter int              TRC_CYC  = 4,
  parameter int              ADDR_W   = 13,
  parameter logic [ADDR_W-1:0] LMR_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  sd_mode_e          mode,
  input  logic              acc_req,
  input  logic              acc_write,
  input  logic              seq_busy,
  input  logic              rf_pending,
  output logic              acc_gnt,
  output logic              seq_start,
  output logic              rf_take,
  output sd_cmd_t           cmd_o,
  output logic              a10_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              inval_o
);

  localparam int WMAX   = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
  localparam int WCNT_W = $clog2(WMAX + 1);

  rf_state_e         state_q;
  logic [WCNT_W-1:0] wcnt_q;
  sd_cmd_t           cmd_q;
  logic              a10_q;
  logic [ADDR_W-1:0] addr_q;
  logic              inval_q;
  logic              is_idle;

  assign is_idle   = (state_q == ST_IDLE);
  assign rf_take   = is_idle && rf_pending && !seq_busy;
  assign acc_gnt   = is_idle && !rf_pending && !seq_busy && acc_req;
  assign seq_start = acc_gnt && (mode == MODE_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      cmd_q   <= CMD_DESL;
      a10_q   <= 1'b0;
      addr_q  <= '0;
      inval_q <= 1'b0;
    end else begin
      cmd_q   <= CMD_DESL;
      a10_q   <= 1'b0;
      addr_q  <= '0;
      inval_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (rf_take) begin
            cmd_q   <= CMD_PRE;
            a10_q   <= 1'b1;
            wcnt_q  <= WCNT_W'(TRP_CYC - 1);
            state_q <= ST_WAIT_RP;
          end else if (acc_gnt && acc_write) begin
            unique case (mode)
              MODE_NOP:    cmd_q <= CMD_NOP;
              MODE_PREALL: begin
                cmd_q <= CMD_PRE;
                a10_q <= 1'b1;
              end
              MODE_LMR: begin
                cmd_q  <= CMD_LMR;
                addr_q <= LMR_WORD;
              end
              MODE_AREF:   cmd_q <= CMD_REF;
              default:     cmd_q <= CMD_DESL;
            endcase
          end
        end
        ST_WAIT_RP: begin
          if (wcnt_q == '0) begin
            cmd_q   <= CMD_REF;
            wcnt_q  <= WCNT_W'(TRC_CYC - 1);
            state_q <= ST_WAIT_RC;
          end else begin
            wcnt_q <= wcnt_q - WCNT_W'(1);
          end
        end
        ST_WAIT_RC: begin
          if (wcnt_q == '0) begin
            inval_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            wcnt_q <= wcnt_q - WCNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o   = cmd_q;
  assign a10_o   = a10_q;
  assign addr_o  = addr_q;
  assign inval_o = inval_q;

  // Checker state: a refresh from the scheduler must follow a precharge.
  logic seen_pre_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_pre_q <= 1'b0;
    end else if (cmd_q == CMD_PRE) begin
      seen_pre_q <= 1'b1;
    end else if (inval_q) begin
      seen_pre_q <= 1'b0;
    end
  end

  assert_inval_single_R7: assert property (@(posedge clk) disable iff (rst)
    inval_q |=> !inval_q);

  assert_inval_after_pre_R7: assert property (@(posedge clk) disable iff (rst)
    inval_q |-> seen_pre_q);

  assert_pre_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> !$past(seq_busy));

  assert_no_grant_busy_R5: assert property (@(posedge clk) disable iff (rst)
    acc_gnt |-> (!seq_busy && !rf_pending));

  assert_prefers_refresh_R10: assert property (@(posedge clk) disable iff (rst)
    (rf_take && acc_req) |-> !acc_gnt);

endmodule

// File: rtl/sdram_cmd_refresh.sv
module sdram_cmd_refresh
  import sdcr_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TRP_CYC    = 2,
  parameter int TRC_CYC    = 4,
  parameter int ADDR_W     = 13,
  parameter int CAS_LAT    = 2,
  parameter int BURST_CODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [2:0]        mode_code,
  input  logic              rfsh_we,
  input  logic [CNT_W-1:0]  rfsh_period,
  input  logic              acc_req,
  input  logic              acc_write,
  input  logic              seq_busy,
  output logic              acc_gnt,
  output logic              seq_start,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_a10,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              rows_inval,
  output logic              rfsh_overrun
);

  localparam logic [ADDR_W-1:0] LMR_WORD =
    ADDR_W'((CAS_LAT << 4) | (BURST_CODE & 7));

  sd_mode_e mode;
  logic     rf_pending;
  logic     rf_take;
  sd_cmd_t  cmd;

  sdcr_mode_reg u_mode (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (mode_we),
    .wr_code (mode_code),
    .mode_o  (mode)
  );

  sdcr_refresh_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .period_we (rfsh_we),
    .period_in (rfsh_period),
    .take      (rf_take),
    .pending_o (rf_pending),
    .overrun_o (rfsh_overrun)
  );

  sdcr_cmd_fsm #(
    .TRP_CYC  (TRP_CYC),
    .TRC_CYC  (TRC_CYC),
    .ADDR_W   (ADDR_W),
    .LMR_WORD (LMR_WORD)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .acc_req    (acc_req),
    .acc_write  (acc_write),
    .seq_busy   (seq_busy),
    .rf_pending (rf_pending),
    .acc_gnt    (acc_gnt),
    .seq_start  (seq_start),
    .rf_take    (rf_take),
    .cmd_o      (cmd),
    .a10_o      (sd_a10),
    .addr_o     (sd_addr),
    .inval_o    (rows_inval)
  );

  assign sd_cs_n  = cmd.cs_n;
  assign sd_ras_n = cmd.ras_n;
  assign sd_cas_n = cmd.cas_n;
  assign sd_we_n  = cmd.we_n;

endmodule

// File: tb/test_sdram_cmd_refresh.sv
module test_sdram_cmd_refresh;

  localparam int CNT_W  = 16;
  localparam int TRP    = 2;
  localparam int TRC    = 4;
  localparam int ADDR_W = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_we = 1'b0;
  logic [2:0] mode_code = '0;
  logic rfsh_we = 1'b0;
  logic [CNT_W-1:0] rfsh_period = '0;
  logic acc_req = 1'b0, acc_write = 1'b0, seq_busy = 1'b0;
  logic acc_gnt, seq_start, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;
  logic [ADDR_W-1:0] sd_addr;
  logic rows_inval, rfsh_overrun;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  sdram_cmd_refresh #(.CNT_W(CNT_W), .TRP_CYC(TRP), .TRC_CYC(TRC), .ADDR_W(ADDR_W))
  i_sdram_cmd_refresh (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_code(mode_code),
    .rfsh_we(rfsh_we), .rfsh_period(rfsh_period), .acc_req(acc_req),
    .acc_write(acc_write), .seq_busy(seq_busy), .acc_gnt(acc_gnt),
    .seq_start(seq_start), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a10(sd_a10),
    .sd_addr(sd_addr), .rows_inval(rows_inval), .rfsh_overrun(rfsh_overrun)
  );

  // mode[2:0] wr seq_start cmd[3:0] a10
  localparam logic [9:0] VEC [0:6] = '{
    10'b000_1_1_1111_0,
    10'b000_0_1_1111_0,
    10'b001_1_0_0111_0,
    10'b010_1_0_0010_1,
    10'b011_1_0_0000_0,
    10'b100_1_0_0001_0,
    10'b010_0_0_1111_0
  };

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] c);
    mode_we = 1'b1; mode_code = c; tick(); mode_we = 1'b0;
  endtask

  task automatic set_period(input int v);
    rfsh_we = 1'b1; rfsh_period = CNT_W'(v); tick(); rfsh_we = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int quiet;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1: reset state
    chk("R1", "pins", 32'(pins()), 32'hF);
    chk("R1", "a10", 32'(sd_a10), 0);
    chk("R1", "addr", 32'(sd_addr), 0);
    chk("R1", "inval", 32'(rows_inval), 0);
    chk("R1", "overrun", 32'(rfsh_overrun), 0);
    acc_req = 1'b1; acc_write = 1'b1; #1;
    chk("R1", "seq_start in reset mode", 32'(seq_start), 1);
    tick(); acc_req = 1'b0;
    chk("R1", "no cmd in reset mode", 32'(pins()), 32'hF);
    quiet = 1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (pins() !== 4'hF) quiet = 0;
    end
    chk("R1", "timer stopped", 32'(quiet), 1);

    // R3/R4: vector table
    for (int i = 0; i < 7; i++) begin
      set_mode(VEC[i][9:7]);
      acc_req = 1'b1; acc_write = VEC[i][6]; #1;
      chk("R4", "grant", 32'(acc_gnt), 1);
      chk("R4", "seq_start", 32'(seq_start), 32'(VEC[i][5]));
      tick(); acc_req = 1'b0;
      chk("R3", "cmd", 32'(pins()), 32'(VEC[i][4:1]));
      chk("R3", "a10", 32'(sd_a10), 32'(VEC[i][0]));
      chk("R3", "addr", 32'(sd_addr),
          (VEC[i][9:7] == 3'd3 && VEC[i][6]) ? 32'h20 : 32'h0);
      tick();
      chk("R3", "single cmd", 32'(pins()), 32'hF);
    end

    // R2: illegal code ignored
    set_mode(3'd4);
    set_mode(3'd6);
    acc_req = 1'b1; acc_write = 1'b1; tick(); acc_req = 1'b0;
    chk("R2", "mode kept after code 6", 32'(pins()), 32'h1);
    set_mode(3'd0);
    acc_req = 1'b1; acc_write = 1'b1; #1;
    chk("R2", "normal restored", 32'(seq_start), 1);
    tick(); acc_req = 1'b0;

    // R6/R7/R10: refresh timing with a held access request (reads, mode 0)
    acc_req = 1'b1; acc_write = 1'b0;
    set_period(10);
    for (int c = 0; c <= 21; c++) begin
      logic eg; logic [3:0] ec; logic ei;
      eg = !((c >= 10 && c <= 10 + TRP + TRC) || c >= 20);
      ec = (c == 11 || c == 21) ? 4'h2 : (c == 11 + TRP) ? 4'h1 : 4'hF;
      ei = (c == 11 + TRP + TRC);
      #1;
      chk(eg ? "R5" : "R10", "grant", 32'(acc_gnt), 32'(eg));
      chk(c > 11 ? "R7" : "R6", "cmd", 32'(pins()), 32'(ec));
      chk("R7", "inval", 32'(rows_inval), 32'(ei));
      if (c == 11) chk("R7", "pre a10", 32'(sd_a10), 1);
      tick();
    end
    acc_req = 1'b0;
    set_period(0);
    repeat (10) tick();
    quiet = 1;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (pins() !== 4'hF) quiet = 0;
    end
    chk("R6", "zero period stops", 32'(quiet), 1);

    // R5/R8/R9: sequencer busy holds refresh off; overrun
    seq_busy = 1'b1;
    set_period(6);
    quiet = 1;
    for (int c = 0; c < 14; c++) begin
      if (c == 1) begin
        acc_req = 1'b1; acc_write = 1'b1; #1;
        chk("R5", "no grant while busy", 32'(acc_gnt), 0);
        acc_req = 1'b0;
      end
      if (c == 10) chk("R9", "no overrun yet", 32'(rfsh_overrun), 0);
      if (pins() !== 4'hF) quiet = 0;
      tick();
    end
    chk("R8", "no refresh while busy", 32'(quiet), 1);
    chk("R9", "overrun set", 32'(rfsh_overrun), 1);
    seq_busy = 1'b0;
    tick();
    chk("R8", "pre after busy drops", 32'(pins()), 32'h2);
    set_period(0);
    repeat (10) tick();
    chk("R9", "overrun sticky", 32'(rfsh_overrun), 1);

    // R1: reset clears overrun
    rst = 1'b1; tick(); rst = 1'b0; tick();
    chk("R1", "overrun cleared", 32'(rfsh_overrun), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule